// File: doc/BRIEF.md
# Middle-Region Code Span Monitor

This block watches the conversion results of a pipelined converter and measures how wide a span of output codes one 1.5-bit stage's middle decision region covers. Every conversion delivers the corrected output code together with that stage's three-way decision. Only conversions for which the stage decided "middle" count. Over a window whose length is a power of two of valid conversions, the block keeps the smallest and the largest such code. When the window closes it reports their difference. A drift in the stage's residue gain stretches or shrinks this span. A reference-DAC gain error only shifts it. The span therefore isolates the residue gain alone.

At the end of foreground calibration, a one-cycle latch request stores the most recent span as the reference. From then on, each new span is compared with the reference. The block outputs the signed difference and a single-step raise or lower request for the stage's gain coefficient. The request is held back while the difference stays inside a programmable deadband. A system places one such block per stage and sequences the updates from the last stages toward the first.

Top module: `mwt_tracker`

## Requirements
- R1: After a synchronous reset, `width_vld`, `upd_vld`, `coef_inc`, `coef_dec` and `ref_valid` are 0, and `width` and `ref_width` are 0.
- R2: Only samples with `smp_vld`=1 and `smp_region`=2'b01 (middle) change the tracked extremes. Region codes 2'b00 (low), 2'b10 (high) and 2'b11 (unused), and any sample with `smp_vld`=0, have no effect on the reported span.
- R3: A window is 2^`win_log2` valid samples, with `win_log2` limited to MAX_WIN_LOG2. `width_vld` pulses for one cycle in the cycle right after the clock edge that takes the last sample of the window.
- R4: `width` equals the largest minus the smallest middle-region code of the window, the last sample included. It holds that value until the next reported span.
- R5: A window with no middle-region sample produces no `width_vld` pulse and leaves `width` unchanged.
- R6: The extremes restart at every window boundary, so codes from an earlier window never widen a later span.
- R7: When `ref_latch` is high at a clock edge and a span has already been reported, `ref_width` takes the current `width` at that edge and `ref_valid` rises. Before any span has been reported, `ref_latch` is ignored. Once `ref_valid` is set, it stays set until reset.
- R8: No `upd_vld`, `coef_inc` or `coef_dec` pulse occurs while no reference is held.
- R9: With a reference held, each `width_vld` pulse is followed one cycle later by a one-cycle `upd_vld` pulse. In that cycle, `width_err` = `width` − `ref_width` as a signed (CODE_W+1)-bit value.
- R10: When `upd_vld` is high: if `width_err` > `dead_thr`, `coef_dec`=1; if `width_err` < −`dead_thr`, `coef_inc`=1; otherwise both are 0. `coef_inc` and `coef_dec` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | A conversion result is present |
| smp_code | input | CODE_W | Corrected output code |
| smp_region | input | 2 | Stage decision: 00 low, 01 middle, 10 high, 11 unused |
| win_log2 | input | WLOG_W | Window length exponent |
| dead_thr | input | CODE_W | Deadband half-width in codes |
| ref_latch | input | 1 | Capture the current span as reference |
| width_vld | output | 1 | New span reported |
| width | output | CODE_W | Last reported span |
| ref_valid | output | 1 | Reference has been captured |
| ref_width | output | CODE_W | Stored reference span |
| upd_vld | output | 1 | Comparison result valid |
| width_err | output | CODE_W+1 | Signed span minus reference |
| coef_inc | output | 1 | Request one step up of the gain coefficient |
| coef_dec | output | 1 | Request one step down of the gain coefficient |

## Verification
The bench mixes low, high and unused region codes, and invalid middle codes, into the windows. A tracker that does not filter on the decision would report a far wider span. It runs a window with no middle sample, where a design without the seen flag would report a bogus span from the reset values. It moves between windows with very different code ranges, which would expose extremes carried across a boundary. It sweeps errors exactly at ±threshold and just beyond, which catches an off-by-one deadband or swapped raise/lower requests. The full-scale span of 0 to the top code and the one-sample window are also covered. A latch request before any measurement is issued, and the bench checks that it is ignored.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

    localparam int CODE_W       = 12;
    localparam int MAX_WIN_LOG2 = 10;
    localparam int WLOG_W       = $clog2(MAX_WIN_LOG2 + 1);
    localparam int CNT_W        = MAX_WIN_LOG2;

    typedef logic [CODE_W-1:0]        code_t;
    typedef logic signed [CODE_W:0]   err_t;
    typedef logic [WLOG_W-1:0]        wlog_t;
    typedef logic [CNT_W-1:0]         cnt_t;

    typedef enum logic [1:0] {
        REG_LOW  = 2'b00,
        REG_MID  = 2'b01,
        REG_HIGH = 2'b10,
        REG_RSVD = 2'b11
    } region_e;

    typedef enum logic [1:0] {
        REQ_HOLD = 2'b00,
        REQ_UP   = 2'b01,
        REQ_DOWN = 2'b10
    } req_e;

    typedef struct packed {
        logic  seen;
        code_t lo;
        code_t hi;
    } span_t;

    // widen a span with one more code
    function automatic span_t span_merge(span_t s, code_t c);
        span_t r;
        r = s;
        if (!s.seen) begin
            r.seen = 1'b1;
            r.lo   = c;
            r.hi   = c;
        end else begin
            if (c < s.lo) r.lo = c;
            if (c > s.hi) r.hi = c;
        end
        return r;
    endfunction

    function automatic err_t width_diff(code_t a, code_t b);
        return $signed({1'b0, a}) - $signed({1'b0, b});
    endfunction

    function automatic req_e deadband(err_t e, code_t thr);
        err_t t;
        t = $signed({1'b0, thr});
        if (e > t)       return REQ_DOWN;
        else if (e < -t) return REQ_UP;
        return REQ_HOLD;
    endfunction

    // last count index of a window of 2^k samples, k clamped to range
    function automatic cnt_t win_mask(wlog_t k);
        wlog_t            kc;
        logic [CNT_W:0]   pw;
        kc = (k > wlog_t'(MAX_WIN_LOG2)) ? wlog_t'(MAX_WIN_LOG2) : k;
        pw = (CNT_W+1)'(1) << kc;
        return cnt_t'(pw - (CNT_W+1)'(1));
    endfunction

endpackage

// File: rtl/mwt_win_ctr.sv
module mwt_win_ctr
    import mwt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  smp_vld,
    input  wlog_t win_log2,
    output logic  win_end
);
    cnt_t cnt_q;
    cnt_t last_idx;

    always_comb begin
        last_idx = win_mask(win_log2);
        win_end  = smp_vld && (cnt_q >= last_idx);
    end

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (win_end)  cnt_q <= '0;
        else if (smp_vld)  cnt_q <= cnt_q + cnt_t'(1);
    end

    // R3: a window boundary always restarts the count
    a_r3_cnt_restart: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (cnt_q == '0));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(cnt_q));

endmodule

// File: rtl/mwt_span_trk.sv
module mwt_span_trk
    import mwt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  code_t code,
    input  logic  clr,
    output span_t span_nxt
);
    span_t span_q;

    always_comb begin
        span_nxt = take ? span_merge(span_q, code) : span_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) span_q <= '0;
        else            span_q <= span_nxt;
    end

    // R2: nothing but a middle sample moves the extremes
    a_r2_ignore_other: assert property (@(posedge clk) disable iff (rst)
        (!take && !clr) |=> $stable(span_q));

    // R4: extremes stay ordered
    a_r4_ordered: assert property (@(posedge clk) disable iff (rst)
        span_q.seen |-> (span_q.lo <= span_q.hi));

    // R6: a boundary clears the tracker
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        clr |=> !span_q.seen);

endmodule

// File: rtl/mwt_ref_cmp.sv
module mwt_ref_cmp
    import mwt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  width_vld,
    input  code_t width,
    input  logic  ref_latch,
    input  code_t dead_thr,
    output logic  ref_valid,
    output code_t ref_width,
    output logic  upd_vld,
    output err_t  width_err,
    output logic  coef_inc,
    output logic  coef_dec
);
    logic  have_meas_q;
    logic  ref_ok_q;
    code_t ref_q;
    logic  upd_q;
    err_t  err_q;
    req_e  req_q;
    err_t  err_nxt;

    always_comb err_nxt = width_diff(width, ref_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            have_meas_q <= 1'b0;
            ref_ok_q    <= 1'b0;
            ref_q       <= '0;
            upd_q       <= 1'b0;
            err_q       <= '0;
            req_q       <= REQ_HOLD;
        end else begin
            if (width_vld) have_meas_q <= 1'b1;
            if (ref_latch && have_meas_q) begin
                ref_q    <= width;
                ref_ok_q <= 1'b1;
            end
            upd_q <= width_vld && ref_ok_q;
            if (width_vld && ref_ok_q) begin
                err_q <= err_nxt;
                req_q <= deadband(err_nxt, dead_thr);
            end else begin
                req_q <= REQ_HOLD;
            end
        end
    end

    assign ref_valid = ref_ok_q;
    assign ref_width = ref_q;
    assign upd_vld   = upd_q;
    assign width_err = err_q;
    assign coef_inc  = (req_q == REQ_UP);
    assign coef_dec  = (req_q == REQ_DOWN);

    // R7: reference, once held, persists
    a_r7_ref_sticky: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> ref_valid);

    // R8: no update without reference
    a_r8_needs_ref: assert property (@(posedge clk) disable iff (rst)
        upd_vld |-> ref_valid);

    // R9: update follows a reported span
    a_r9_follows_span: assert property (@(posedge clk) disable iff (rst)
        upd_vld |-> $past(width_vld));

    // R10: requests exclusive and only with an update
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(coef_inc && coef_dec));

    a_r10_with_upd: assert property (@(posedge clk) disable iff (rst)
        (coef_inc || coef_dec) |-> upd_vld);

endmodule

// File: rtl/mwt_tracker.sv
module mwt_tracker
    import mwt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld,
    input  logic [CODE_W-1:0]    smp_code,
    input  logic [1:0]           smp_region,
    input  logic [WLOG_W-1:0]    win_log2,
    input  logic [CODE_W-1:0]    dead_thr,
    input  logic                 ref_latch,
    output logic                 width_vld,
    output logic [CODE_W-1:0]    width,
    output logic                 ref_valid,
    output logic [CODE_W-1:0]    ref_width,
    output logic                 upd_vld,
    output logic signed [CODE_W:0] width_err,
    output logic                 coef_inc,
    output logic                 coef_dec
);
    logic  win_end;
    logic  take_mid;
    span_t span_nxt;
    logic  wvld_q;
    code_t width_q;

    assign take_mid = smp_vld && (region_e'(smp_region) == REG_MID);

    mwt_win_ctr u_win (
        .clk      (clk),
        .rst      (rst),
        .smp_vld  (smp_vld),
        .win_log2 (win_log2),
        .win_end  (win_end)
    );

    mwt_span_trk u_trk (
        .clk      (clk),
        .rst      (rst),
        .take     (take_mid),
        .code     (smp_code),
        .clr      (win_end),
        .span_nxt (span_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wvld_q  <= 1'b0;
            width_q <= '0;
        end else begin
            wvld_q <= win_end && span_nxt.seen;
            if (win_end && span_nxt.seen)
                width_q <= span_nxt.hi - span_nxt.lo;
        end
    end

    assign width_vld = wvld_q;
    assign width     = width_q;

    mwt_ref_cmp u_cmp (
        .clk       (clk),
        .rst       (rst),
        .width_vld (wvld_q),
        .width     (width_q),
        .ref_latch (ref_latch),
        .dead_thr  (dead_thr),
        .ref_valid (ref_valid),
        .ref_width (ref_width),
        .upd_vld   (upd_vld),
        .width_err (width_err),
        .coef_inc  (coef_inc),
        .coef_dec  (coef_dec)
    );

    // R3: a span is only reported right after a window boundary
    a_r3_after_end: assert property (@(posedge clk) disable iff (rst)
        width_vld |-> $past(win_end));

    // R5: width holds between reports
    a_r5_width_holds: assert property (@(posedge clk) disable iff (rst)
        !width_vld |-> $stable(width));

endmodule

// File: tb/mwt_tracker_tb_top.sv
module mwt_tracker_tb_top;
    import mwt_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        smp_vld = 1'b0;
    code_t       smp_code = '0;
    logic [1:0]  smp_region = 2'b00;
    wlog_t       win_log2 = '0;
    code_t       dead_thr = '0;
    logic        ref_latch = 1'b0;
    logic        width_vld, ref_valid, upd_vld, coef_inc, coef_dec;
    code_t       width, ref_width;
    err_t        width_err;

    mwt_tracker dut_i (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_code(smp_code),
        .smp_region(smp_region), .win_log2(win_log2), .dead_thr(dead_thr),
        .ref_latch(ref_latch), .width_vld(width_vld), .width(width),
        .ref_valid(ref_valid), .ref_width(ref_width), .upd_vld(upd_vld),
        .width_err(width_err), .coef_inc(coef_inc), .coef_dec(coef_dec)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int cyc; int w; } wexp_t;
    typedef struct { int cyc; int e; bit inc; bit dec; } uexp_t;
    wexp_t wq[$];
    uexp_t uq[$];
    wexp_t wx;
    uexp_t ux;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // reference model state
    int m_cnt = 0, m_k = 0, m_lo = 0, m_hi = 0, m_ref = 0, m_thr = 0, m_last = 0;
    bit m_seen = 0, m_have = 0, m_ref_ok = 0;

    task automatic smp(int c, logic [1:0] rg);
        int w, e;
        @(negedge clk);
        smp_vld = 1'b1; smp_code = code_t'(c); smp_region = rg;
        if (rg == 2'b01) begin
            if (!m_seen) begin m_seen = 1; m_lo = c; m_hi = c; end
            else begin
                if (c < m_lo) m_lo = c;
                if (c > m_hi) m_hi = c;
            end
        end
        if (m_cnt == (1 << m_k) - 1) begin
            m_cnt = 0;
            if (m_seen) begin
                w = m_hi - m_lo;
                wq.push_back('{cyc + 1, w});
                m_last = w; m_have = 1;
                if (m_ref_ok) begin
                    e = w - m_ref;
                    uq.push_back('{cyc + 2, e, e < -m_thr, e > m_thr});
                end
            end
            m_seen = 0;
        end else m_cnt++;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            smp_vld = 1'b0; smp_code = code_t'(2222); smp_region = 2'b01;
        end
    endtask

    task automatic set_win(int k);
        @(negedge clk);
        win_log2 = wlog_t'(k); m_k = k;
    endtask

    task automatic latch_ref();
        @(negedge clk); ref_latch = 1'b1;
        @(negedge clk); ref_latch = 1'b0;
        if (m_have) begin m_ref_ok = 1; m_ref = m_last; end
    endtask

    // eight samples: two middle codes among other regions (k = 3)
    task automatic win8(int a, int b);
        smp(a, 2'b01); smp(1, 2'b00); smp(4000, 2'b10); smp(3, 2'b11);
        smp(b, 2'b01); smp(2, 2'b00); smp(4090, 2'b10); smp(0, 2'b00);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (width_vld) begin
                if (wq.size() == 0) chk(0, "R5", "unexpected width_vld", 1, 0);
                else begin
                    wx = wq.pop_front();
                    chk(wx.cyc == cyc, "R3", "width_vld cycle", cyc, wx.cyc);
                    chk(int'(width) == wx.w, "R4", "width", int'(width), wx.w);
                end
            end else if (wq.size() > 0 && wq[0].cyc <= cyc) begin
                chk(0, "R3", "missing width_vld", 0, 1);
                void'(wq.pop_front());
            end
            if (upd_vld) begin
                if (uq.size() == 0) chk(0, "R8", "unexpected upd_vld", 1, 0);
                else begin
                    ux = uq.pop_front();
                    chk(ux.cyc == cyc, "R9", "upd_vld cycle", cyc, ux.cyc);
                    chk(int'(width_err) == ux.e, "R9", "width_err", int'(width_err), ux.e);
                    chk(coef_inc == ux.inc, "R10", "coef_inc", int'(coef_inc), int'(ux.inc));
                    chk(coef_dec == ux.dec, "R10", "coef_dec", int'(coef_dec), int'(ux.dec));
                end
            end else begin
                if (coef_inc || coef_dec) chk(0, "R10", "request without upd_vld", 1, 0);
                if (uq.size() > 0 && uq[0].cyc <= cyc) begin
                    chk(0, "R9", "missing upd_vld", 0, 1);
                    void'(uq.pop_front());
                end
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            chk(0, "WD", "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(width_vld == 0, "R1", "width_vld", int'(width_vld), 0);
        chk(upd_vld == 0,   "R1", "upd_vld", int'(upd_vld), 0);
        chk(ref_valid == 0, "R1", "ref_valid", int'(ref_valid), 0);
        chk(!coef_inc && !coef_dec, "R1", "coef requests", int'({coef_inc, coef_dec}), 0);
        chk(width == 0 && ref_width == 0, "R1", "width/ref_width", int'(width), 0);
        rst = 1'b0;

        // R7: latch before any span is ignored
        latch_ref();
        chk(ref_valid == 0, "R7", "early latch ignored", int'(ref_valid), 0);

        // R2/R4: other regions filtered out, window of 4
        set_win(2);
        smp(100, 2'b01); smp(140, 2'b01); smp(5, 2'b00); smp(120, 2'b01);
        idle(3);
        // R5: no middle sample, invalid middle codes interleaved (R2)
        smp(3000, 2'b10); smp(7, 2'b00); idle(2);
        smp(2000, 2'b10); smp(9, 2'b11);
        idle(3);
        chk(width == 40, "R5", "width kept after empty window", int'(width), 40);
        // R6: new window does not inherit old extremes
        smp(500, 2'b01); smp(510, 2'b01); smp(505, 2'b01); smp(502, 2'b01);
        idle(3);

        // R7: capture reference
        latch_ref();
        chk(ref_valid == 1, "R7", "ref_valid", int'(ref_valid), 1);
        chk(ref_width == 10, "R7", "ref_width", int'(ref_width), 10);

        // R9/R10: deadband sweep, thr = 3, ref = 10
        @(negedge clk); dead_thr = code_t'(3); m_thr = 3;
        set_win(3);
        win8(500, 514);   // +4 dec
        win8(600, 607);   // -3 hold
        win8(700, 713);   // +3 hold
        win8(50, 55);     // -5 inc
        win8(900, 900);   // -10 inc
        win8(0, 4095);    // full scale, dec
        idle(3);

        // R3: one-sample windows
        set_win(0);
        smp(77, 2'b01);
        smp(78, 2'b00);
        smp(4095, 2'b01);
        idle(4);
        chk(ref_valid == 1, "R7", "ref_valid sticky", int'(ref_valid), 1);

        chk(wq.size() == 0, "R3", "pending width results", wq.size(), 0);
        chk(uq.size() == 0, "R9", "pending updates", uq.size(), 0);
        done = 1;
        summary();
        $finish;
    end

endmodule